// File: doc/BRIEF.md
# Address Aperture Decoder

This block sorts every 32-bit processor address into one of three regions of the 4 GB space: local SDRAM, memory-mapped I/O, or the PCI region that takes everything else. The SDRAM region runs from a programmable base up to a programmable end. The I/O region is a fixed 2 MB window whose start is programmable. A small set of configuration registers holds these values. They are loaded through a write port made of an enable, a 3-bit register select and a 32-bit data word.

For an SDRAM address, the block also selects one of four memory ranks and gives the byte offset inside that rank. Rank sizes come from a configuration register, not from the address. The ranks sit back to back, starting at the SDRAM base. An SDRAM address that lies beyond the last configured rank raises a miss flag and selects no rank. Every result is registered, so the decode of an address appears one clock after the address is presented.

Top module: `aperture_decoder`

## Requirements
- R1: Synchronous active-high reset sets the SDRAM start and end to 0, so the SDRAM region is empty. It sets the I/O start to 0xEFE00000 and disables all ranks. While reset is held, the outputs show sel_pci=1 with every other output at 0.
- R2: Exactly one of sel_sdram, sel_mmio and sel_pci is 1 in every cycle. The decode of addr_in sampled at clock edge N appears on the outputs just after edge N, and stays there until edge N+1.
- R3: An address A is in the SDRAM region when start <= A < end, with end exclusive. When end <= start, the region is empty.
- R4: An address A is in the I/O region when io_start <= A < io_start + 0x200000, computed without wrap past 0xFFFFFFFF.
- R5: An address that lies in both the SDRAM region and the I/O region is reported as I/O.
- R6: When end - start exceeds 64 MB, the SDRAM region is cut to start + 64 MB.
- R7: An address in neither region gives sel_pci=1.
- R8: The cfg_sel codes are 0 = SDRAM start, 1 = SDRAM end, 2 = I/O start, 3 = rank setup (cfg_wdata[15:0]). A write with cfg_sel 4 to 7 changes nothing. A write is used by decodes from the following clock edge on. An address sampled on the same edge as the write still uses the old settings.
- R9: The rank setup register holds 4 bits per rank r, at bits [4r+3:4r]. Bit 4r+3 enables the rank. Bits [4r+2:4r] hold a size code c, and the rank size is 512 KB << c. Codes 6 and 7 mean 16 MB.
- R10: Enabled ranks are packed upward from the SDRAM start in order 0 to 3. A disabled rank takes up no space. rank_cs has at most one bit set, bit r for rank r. rank_offset is A - start - (the start of rank r within the region).
- R11: An SDRAM address at or past the end of the last enabled rank gives rank_miss=1, rank_cs=0 and rank_offset=0.
- R12: When sel_sdram is 0, rank_cs, rank_offset and rank_miss are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| addr_in | input | 32 | Address to classify |
| sel_sdram | output | 1 | Address is in the SDRAM region |
| sel_mmio | output | 1 | Address is in the I/O region |
| sel_pci | output | 1 | Address is in the PCI region |
| rank_cs | output | 4 | One-hot rank chip select |
| rank_offset | output | 24 | Byte offset inside the selected rank |
| rank_miss | output | 1 | SDRAM address lies past the last enabled rank |

## Verification
A configuration write and an address decode can fall in the same cycle. The case that matters is an address that the write moves from one region to another. The bench raises the write enable together with an address equal to the old I/O start, and the write moves that start elsewhere. The result after that edge must still report I/O, following the old settings. The same address presented on the next edge must then follow the new settings.

// File: rtl/apdec_pkg.sv
package apdec_pkg;

    localparam int ADDR_W        = 32;
    localparam int SEL_W         = 3;
    localparam int RANK_FIELD_W  = 4;
    localparam int SIZE_CODE_W   = 3;
    localparam int MIN_RANK_LOG2 = 19;
    localparam int MAX_SIZE_CODE = 5;
    localparam int RANK_OFF_W    = MIN_RANK_LOG2 + MAX_SIZE_CODE;
    localparam int SD_SPAN_LOG2  = 26;
    localparam int SD_OFF_W      = SD_SPAN_LOG2 + 1;

    localparam logic [ADDR_W-1:0] MMIO_RESET_BASE = 32'hEFE0_0000;
    localparam logic [ADDR_W:0]   MMIO_SPAN       = 33'h0_0020_0000;
    localparam logic [ADDR_W:0]   SD_MAX_SPAN     = 33'h0_0400_0000;

    typedef enum logic [SEL_W-1:0] {
        CFG_SD_START = 3'd0,
        CFG_SD_END   = 3'd1,
        CFG_IO_START = 3'd2,
        CFG_RANKS    = 3'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   span;
    } window_t;

    typedef struct packed {
        logic sdram;
        logic mmio;
        logic pci;
        logic miss;
    } ap_flags_t;

    // Byte size of one rank from its enable bit and size code.
    function automatic logic [SD_OFF_W-1:0] rank_bytes(input logic en,
                                                       input logic [SIZE_CODE_W-1:0] code);
        logic [SD_OFF_W-1:0] one;
        int unsigned         c;
        one = SD_OFF_W'(1);
        c   = (int'(code) > MAX_SIZE_CODE) ? MAX_SIZE_CODE : int'(code);
        if (!en) return '0;
        return one << (MIN_RANK_LOG2 + c);
    endfunction

    // SDRAM span: zero when the end does not lie above the start, capped at 64 MB.
    function automatic logic [ADDR_W:0] sd_span(input logic [ADDR_W-1:0] start,
                                                input logic [ADDR_W-1:0] stop);
        logic [ADDR_W:0] d;
        if (stop <= start) return '0;
        d = {1'b0, stop} - {1'b0, start};
        return (d > SD_MAX_SPAN) ? SD_MAX_SPAN : d;
    endfunction

endpackage

// File: rtl/apdec_regs.sv
module apdec_regs
    import apdec_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    localparam int RCFG_W   = RANK_FIELD_W * NUM_RANKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] sd_start,
    output logic [ADDR_W-1:0] sd_end,
    output logic [ADDR_W-1:0] io_start,
    output logic [RCFG_W-1:0] rank_cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_start <= '0;
            sd_end   <= '0;
            io_start <= MMIO_RESET_BASE;
            rank_cfg <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                CFG_SD_START: sd_start <= wdata;
                CFG_SD_END:   sd_end   <= wdata;
                CFG_IO_START: io_start <= wdata;
                CFG_RANKS:    rank_cfg <= wdata[RCFG_W-1:0];
                default: ;
            endcase
        end
    end

    p_io_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (io_start == MMIO_RESET_BASE && sd_end == '0 && rank_cfg == '0));

    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == CFG_IO_START) |=> (io_start == $past(wdata)));

    p_bad_sel_r8: assert property (@(posedge clk) disable iff (rst)
        (we && sel > CFG_RANKS) |=> $stable({sd_start, sd_end, io_start, rank_cfg}));

endmodule

// File: rtl/apdec_window.sv
module apdec_window
    import apdec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  window_t           win,
    output logic              hit
);

    logic [ADDR_W:0] diff;

    // A borrow into the top bit means the address lies below the base.
    always_comb begin
        diff = {1'b0, addr} - {1'b0, win.base};
        hit  = !diff[ADDR_W] && (diff < win.span);
    end

endmodule

// File: rtl/apdec_rank_map.sv
module apdec_rank_map
    import apdec_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    localparam int RCFG_W   = RANK_FIELD_W * NUM_RANKS,
    localparam int BND_W    = SD_OFF_W + $clog2(NUM_RANKS + 1)
) (
    input  logic [SD_OFF_W-1:0]   off,
    input  logic [RCFG_W-1:0]     rank_cfg,
    output logic [NUM_RANKS-1:0]  cs,
    output logic [RANK_OFF_W-1:0] rank_off
);

    logic [NUM_RANKS:0][BND_W-1:0] bound;
    logic [BND_W-1:0]              off_x;

    assign bound[0] = '0;
    assign off_x    = BND_W'(off);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic                   en;
        logic [SIZE_CODE_W-1:0] code;
        assign en   = rank_cfg[RANK_FIELD_W*r + RANK_FIELD_W - 1];
        assign code = rank_cfg[RANK_FIELD_W*r +: SIZE_CODE_W];
        assign bound[r+1] = bound[r] + BND_W'(rank_bytes(en, code));
        assign cs[r] = en && (off_x >= bound[r]) && (off_x < bound[r+1]);
    end

    always_comb begin
        rank_off = '0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            if (cs[r]) rank_off = RANK_OFF_W'(off_x - bound[r]);
        end
    end

endmodule

// File: rtl/aperture_decoder.sv
module aperture_decoder
    import apdec_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    localparam int RCFG_W   = RANK_FIELD_W * NUM_RANKS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    input  logic [ADDR_W-1:0]     addr_in,
    output logic                  sel_sdram,
    output logic                  sel_mmio,
    output logic                  sel_pci,
    output logic [NUM_RANKS-1:0]  rank_cs,
    output logic [RANK_OFF_W-1:0] rank_offset,
    output logic                  rank_miss
);

    logic [ADDR_W-1:0]     sd_start, sd_end, io_start;
    logic [RCFG_W-1:0]     rank_cfg;
    window_t               sd_win, io_win;
    logic                  sd_hit, io_hit;
    logic [SD_OFF_W-1:0]   sd_off;
    logic [NUM_RANKS-1:0]  cs_raw;
    logic [RANK_OFF_W-1:0] roff_raw;
    ap_flags_t             flags_n, flags_q;
    logic [NUM_RANKS-1:0]  cs_n;
    logic [RANK_OFF_W-1:0] roff_n;

    apdec_regs #(.NUM_RANKS(NUM_RANKS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .sd_start (sd_start),
        .sd_end   (sd_end),
        .io_start (io_start),
        .rank_cfg (rank_cfg)
    );

    always_comb begin
        sd_win.base = sd_start;
        sd_win.span = sd_span(sd_start, sd_end);
        io_win.base = io_start;
        io_win.span = MMIO_SPAN;
    end

    apdec_window u_sd_win (.addr(addr_in), .win(sd_win), .hit(sd_hit));
    apdec_window u_io_win (.addr(addr_in), .win(io_win), .hit(io_hit));

    assign sd_off = SD_OFF_W'(addr_in - sd_start);

    apdec_rank_map #(.NUM_RANKS(NUM_RANKS)) u_ranks (
        .off      (sd_off),
        .rank_cfg (rank_cfg),
        .cs       (cs_raw),
        .rank_off (roff_raw)
    );

    // Fixed priority: I/O first, then SDRAM, then the PCI catch-all.
    always_comb begin
        flags_n.mmio  = io_hit;
        flags_n.sdram = sd_hit && !io_hit;
        flags_n.pci   = !sd_hit && !io_hit;
        flags_n.miss  = flags_n.sdram && (cs_raw == '0);
        cs_n          = flags_n.sdram ? cs_raw : '0;
        roff_n        = flags_n.sdram ? roff_raw : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q     <= '{sdram: 1'b0, mmio: 1'b0, pci: 1'b1, miss: 1'b0};
            rank_cs     <= '0;
            rank_offset <= '0;
        end else begin
            flags_q     <= flags_n;
            rank_cs     <= cs_n;
            rank_offset <= roff_n;
        end
    end

    assign sel_sdram = flags_q.sdram;
    assign sel_mmio  = flags_q.mmio;
    assign sel_pci   = flags_q.pci;
    assign rank_miss = flags_q.miss;

    p_one_region_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({sel_sdram, sel_mmio, sel_pci}) == 1);

    p_io_latency_r2: assert property (@(posedge clk) disable iff (rst)
        io_hit |=> sel_mmio);

    p_io_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (io_hit && sd_hit) |=> (sel_mmio && !sel_sdram));

    p_cs_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rank_cs));

    p_miss_clean_r11: assert property (@(posedge clk) disable iff (rst)
        rank_miss |-> (sel_sdram && rank_cs == '0 && rank_offset == '0));

    p_idle_rank_r12: assert property (@(posedge clk) disable iff (rst)
        !sel_sdram |-> (rank_cs == '0 && rank_offset == '0 && !rank_miss));

endmodule

// File: tb/aperture_decoder_tb_top.sv
`timescale 1ns/1ps
module aperture_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] addr_in = '0;
    logic        sel_sdram, sel_mmio, sel_pci, rank_miss;
    logic [3:0]  rank_cs;
    logic [23:0] rank_offset;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench copy of the settings, kept from the writes it issues.
    logic [31:0] m_start = '0, m_end = '0, m_io = 32'hEFE0_0000;
    logic [15:0] m_ranks = '0;

    always #2.5 clk = ~clk;

    aperture_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .addr_in(addr_in), .sel_sdram(sel_sdram), .sel_mmio(sel_mmio), .sel_pci(sel_pci),
        .rank_cs(rank_cs), .rank_offset(rank_offset), .rank_miss(rank_miss)
    );

    // Expected outputs packed as {sdram, mmio, pci, miss, cs[3:0], offset[23:0]}.
    function automatic logic [31:0] expect_for(input logic [31:0] a);
        logic [32:0] io_d, sd_d, span;
        logic        io, sd, miss;
        logic [3:0]  cs;
        logic [23:0] off;
        logic [27:0] lo, sz, rel;
        io_d = {1'b0, a} - {1'b0, m_io};
        io   = (a >= m_io) && (io_d < 33'h20_0000);
        if (m_end <= m_start) span = '0;
        else begin
            span = {1'b0, m_end} - {1'b0, m_start};
            if (span > 33'h400_0000) span = 33'h400_0000;
        end
        sd_d = {1'b0, a} - {1'b0, m_start};
        sd   = (a >= m_start) && (sd_d < span) && !io;
        cs = '0; off = '0; lo = '0;
        rel = sd_d[27:0];
        for (int r = 0; r < 4; r++) begin
            int c;
            c  = int'(m_ranks[4*r +: 3]);
            if (c > 5) c = 5;
            sz = m_ranks[4*r+3] ? (28'd1 << (19 + c)) : 28'd0;
            if (sd && sz != 0 && rel >= lo && rel < lo + sz) begin
                cs[r] = 1'b1;
                off   = 24'(rel - lo);
            end
            lo = lo + sz;
        end
        miss = sd && (cs == '0);
        return {sd, io, !sd && !io, miss, cs, off};
    endfunction

    function automatic logic [31:0] actual();
        return {sel_sdram, sel_mmio, sel_pci, rank_miss, rank_cs, rank_offset};
    endfunction

    task automatic compare(input string req, input logic [31:0] exp, input logic [31:0] a);
        n_run++;
        if (actual() !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, actual(), exp);
        end
    endtask

    task automatic probe(input string req, input logic [31:0] a);
        logic [31:0] exp;
        @(negedge clk);
        addr_in = a;
        exp = expect_for(a);
        @(posedge clk);
        #1;
        compare(req, exp, a);
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0: m_start = data;
            3'd1: m_end   = data;
            3'd2: m_io    = data;
            3'd3: m_ranks = data[15:0];
            default: ;
        endcase
    endtask

    task automatic t_reset();
        n_run++;
        if (actual() !== {4'b0010, 28'h0}) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%h expected=%h", actual(), {4'b0010, 28'h0});
        end
        rst = 1'b0;
        probe("R1", 32'hEFE0_0000);
        probe("R1", 32'h0000_0000);
        probe("R4", 32'hEFFF_FFFF);
        probe("R4", 32'hF000_0000);
        probe("R7", 32'hEFDF_FFFF);
    endtask

    task automatic t_sdram_ranks();
        cfg_write(3'd0, 32'h0100_0000);
        cfg_write(3'd1, 32'h0180_0000);
        cfg_write(3'd3, 32'h0000_00BA);   // rank0 2 MB, rank1 4 MB
        probe("R3", 32'h0100_0000);
        probe("R10", 32'h011F_FFFF);
        probe("R10", 32'h0120_0000);
        probe("R10", 32'h015F_FFFF);
        probe("R11", 32'h0160_0000);
        probe("R11", 32'h017F_FFFF);
        probe("R3", 32'h0180_0000);
        probe("R12", 32'h00FF_FFFF);
    endtask

    task automatic t_gap_and_codes();
        cfg_write(3'd3, 32'h0000_F80A);   // rank0 2 MB, rank1 off, rank2 512 KB, rank3 code 7
        probe("R10", 32'h0120_0000);
        probe("R9", 32'h0127_FFFF);
        probe("R9", 32'h0128_0000);
        probe("R9", 32'h017F_FFFF);
    endtask

    task automatic t_empty();
        cfg_write(3'd1, 32'h0100_0000);
        probe("R3", 32'h0100_0000);
        cfg_write(3'd1, 32'h0080_0000);
        probe("R3", 32'h0090_0000);
    endtask

    task automatic t_clamp();
        cfg_write(3'd0, 32'h0200_0000);
        cfg_write(3'd1, 32'h8000_0000);
        cfg_write(3'd3, 32'h0000_DDDD);   // four 16 MB ranks
        probe("R6", 32'h05FF_FFFF);
        probe("R6", 32'h0600_0000);
        probe("R10", 32'h0500_0010);
    endtask

    task automatic t_priority();
        cfg_write(3'd2, 32'h0210_0000);
        probe("R5", 32'h0210_0000);
        probe("R5", 32'h022F_FFFF);
        probe("R5", 32'h0230_0000);
        probe("R5", 32'h020F_FFFF);
    endtask

    task automatic t_ignored_sel();
        cfg_write(3'd5, 32'h0000_0000);
        cfg_write(3'd7, 32'hFFFF_FFFF);
        probe("R8", 32'h0210_0000);
        probe("R8", 32'h0300_0000);
    endtask

    task automatic t_same_cycle();
        logic [31:0] exp;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 32'hFFF0_0000;
        addr_in = 32'h0210_0000;
        exp = expect_for(32'h0210_0000);
        @(posedge clk);
        #1;
        compare("R8", exp, 32'h0210_0000);
        @(negedge clk);
        cfg_we = 1'b0;
        m_io = 32'hFFF0_0000;
        probe("R8", 32'h0210_0000);
        probe("R4", 32'hFFFF_FFFF);
        probe("R4", 32'h0000_0000);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_sdram_ranks();
        t_gap_and_codes();
        t_empty();
        t_clamp();
        t_priority();
        t_ignored_sel();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule